// File: doc/BRIEF.md
# Free-Running Event-Timer Main Counter

This block holds the main count of an event-timer unit: a 64-bit up-counter that advances on a tick-enable pulse while the run input is high and holds its value while the counter is halted. Software reaches the count over a simple request/response register bus that carries either 32-bit or 64-bit accesses. A mode input selects whether the counter behaves as a 32-bit or a 64-bit counter.

The counter sits in an eight-byte window. A wide access must start at the window base. A narrow access must start at the base, for the low half, or at base plus four, for the high half. Any other starting byte gets an error response and is not serviced. A write loads the count only while the counter is halted. If a write arrives while the counter is running, it is dropped and the response says so.

Every response arrives one cycle after its request. A legal read taken while the counter is running also advances the count, so reads issued back to back never return the same value.

Top module: `evt_main_counter`

## Requirements
- R1: After reset the count is zero and no response is pending. The first wide read returns 0.
- R2: While `run_i` is high, each cycle with `tick_i` high adds one to the count. While `run_i` is low, the count holds regardless of `tick_i`.
- R3: A wide read at offset F0h returns the whole count. A narrow read at F0h returns bits 31:0 of the count, and a narrow read at F4h returns bits 63:32. Both narrow reads place the value in `rsp_rdata_o[31:0]` with `rsp_rdata_o[63:32]` zero.
- R4: These accesses are illegal and set `rsp_err_o`: a wide access at any offset other than F0h, and a narrow access at any offset other than F0h or F4h. An illegal access returns all-zero read data and leaves the count unchanged.
- R5: A legal write takes effect only while `run_i` is low. A legal write while `run_i` is high leaves the count unchanged and sets `rsp_drop_o`.
- R6: A narrow write at F0h loads `req_wdata_i[31:0]` into count bits 31:0. A narrow write at F4h loads `req_wdata_i[31:0]` into count bits 63:32. In both cases the other half is unchanged. A wide write loads all 64 bits.
- R7: With `wide_i` low, reads of the upper half return zero, and the low half wraps from FFFF_FFFFh to 0.
- R8: With `wide_i` high, the count wraps from all ones to 0.
- R9: A legal read while `run_i` is high advances the count by one even without a tick. Reads issued on consecutive cycles therefore return strictly increasing values unless the count wraps.
- R10: `rsp_valid_o` is high exactly in the cycle after a cycle with `req_valid_i` high. A read returns the count as it stood in the request cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_i | input | 1 | Counter runs when high, halted when low |
| wide_i | input | 1 | 1: 64-bit counter, 0: 32-bit counter |
| tick_i | input | 1 | Tick-enable pulse |
| req_valid_i | input | 1 | Bus request present |
| req_write_i | input | 1 | 1: write, 0: read |
| req_size64_i | input | 1 | 1: 64-bit access, 0: 32-bit access |
| req_addr_i | input | 8 | Byte offset of the access |
| req_wdata_i | input | 64 | Write data (narrow writes use bits 31:0) |
| rsp_valid_o | output | 1 | Response valid |
| rsp_rdata_o | output | 64 | Read data |
| rsp_err_o | output | 1 | Illegal offset or size |
| rsp_drop_o | output | 1 | Write dropped because the counter was running |

## Verification
Directed sequences load known patterns while the counter is halted, so the bench can tell whether a narrow write touched only its own half and whether a wide read assembled both halves correctly. Counts are preloaded just below the 32-bit and 64-bit wrap points to show that the wrap depends on the mode and that narrow-mode upper reads are forced to zero. Back-to-back reads with no ticks separate the read-triggered advance from tick-driven counting. A long random mix of offsets, sizes, run and mode changes, and ticks then checks every response against a bench model, which exposes any mistake in the decoding of illegal offsets, dropped writes, or the priority between loading and counting.

// File: rtl/evt_ctr_pkg.sv
package evt_ctr_pkg;
    // Result of decoding one bus access.
    typedef struct packed {
        logic hit;  // access is legal
        logic lo;   // low half selected
        logic hi;   // high half selected
    } acc_dec_t;
endpackage

// File: rtl/evt_ctr_decode.sv
module evt_ctr_decode
    import evt_ctr_pkg::*;
#(
    parameter int unsigned     AW   = 8,
    parameter logic [AW-1:0]   BASE = 8'hF0
) (
    input  logic [AW-1:0] addr,
    input  logic          size64,
    output acc_dec_t      dec
);
    localparam logic [AW-1:0] HI_OFS = BASE + AW'(4);

    always_comb begin
        dec = '0;
        if (size64) begin
            if (addr == BASE) begin
                dec.hit = 1'b1;
                dec.lo  = 1'b1;
                dec.hi  = 1'b1;
            end
        end else if (addr == BASE) begin
            dec.hit = 1'b1;
            dec.lo  = 1'b1;
        end else if (addr == HI_OFS) begin
            dec.hit = 1'b1;
            dec.hi  = 1'b1;
        end
    end
endmodule

// File: rtl/evt_ctr_core.sv
module evt_ctr_core #(
    parameter int unsigned CW = 64
) (
    input  logic [CW-1:0] cnt_q,
    input  logic          run,
    input  logic          wide,
    input  logic          bump,
    input  logic          ld_lo,
    input  logic          ld_hi,
    input  logic [CW-1:0] wdata,
    output logic [CW-1:0] cnt_d
);
    localparam int unsigned HW = CW / 2;

    always_comb begin
        cnt_d = cnt_q;
        if (!run) begin
            if (ld_lo) cnt_d[HW-1:0] = wdata[HW-1:0];
            if (ld_hi) cnt_d[CW-1:HW] = ld_lo ? wdata[CW-1:HW] : wdata[HW-1:0];
        end else if (bump) begin
            if (wide) cnt_d = cnt_q + CW'(1);
            else      cnt_d[HW-1:0] = cnt_q[HW-1:0] + HW'(1);
        end
    end
endmodule

// File: rtl/evt_main_counter.sv
module evt_main_counter
    import evt_ctr_pkg::*;
#(
    parameter int unsigned   CW   = 64,
    parameter int unsigned   AW   = 8,
    parameter logic [AW-1:0] BASE = 8'hF0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run_i,
    input  logic          wide_i,
    input  logic          tick_i,
    input  logic          req_valid_i,
    input  logic          req_write_i,
    input  logic          req_size64_i,
    input  logic [AW-1:0] req_addr_i,
    input  logic [CW-1:0] req_wdata_i,
    output logic          rsp_valid_o,
    output logic [CW-1:0] rsp_rdata_o,
    output logic          rsp_err_o,
    output logic          rsp_drop_o
);
    localparam int unsigned HW = CW / 2;

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          vld;
        logic          err;
        logic          drop;
        logic [CW-1:0] rdata;
    } state_t;

    state_t        st_d, st_q;
    acc_dec_t      dec;
    logic [CW-1:0] cnt_nx;
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] view;
    logic          rd_hit, wr_hit, bump;

    evt_ctr_decode #(.AW(AW), .BASE(BASE)) u_dec (
        .addr   (req_addr_i),
        .size64 (req_size64_i),
        .dec    (dec)
    );

    assign cnt_q  = st_q.cnt;
    assign rd_hit = req_valid_i && dec.hit && !req_write_i;
    assign wr_hit = req_valid_i && dec.hit && req_write_i;
    assign bump   = tick_i || rd_hit;
    assign view   = wide_i ? st_q.cnt : {{HW{1'b0}}, st_q.cnt[HW-1:0]};

    evt_ctr_core #(.CW(CW)) u_core (
        .cnt_q (st_q.cnt),
        .run   (run_i),
        .wide  (wide_i),
        .bump  (bump),
        .ld_lo (wr_hit && dec.lo),
        .ld_hi (wr_hit && dec.hi),
        .wdata (req_wdata_i),
        .cnt_d (cnt_nx)
    );

    always_comb begin
        st_d       = st_q;
        st_d.cnt   = cnt_nx;
        st_d.vld   = req_valid_i;
        st_d.err   = req_valid_i && !dec.hit;
        st_d.drop  = wr_hit && run_i;
        st_d.rdata = '0;
        if (rd_hit) begin
            if (dec.lo && dec.hi) st_d.rdata = view;
            else if (dec.lo)      st_d.rdata = {{HW{1'b0}}, st_q.cnt[HW-1:0]};
            else                  st_d.rdata = {{HW{1'b0}}, view[CW-1:HW]};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rsp_valid_o = st_q.vld;
    assign rsp_rdata_o = st_q.rdata;
    assign rsp_err_o   = st_q.err;
    assign rsp_drop_o  = st_q.drop;
endmodule

// File: rtl/evt_main_counter_chk.sv
module evt_main_counter_chk #(
    parameter int unsigned   CW   = 64,
    parameter int unsigned   AW   = 8,
    parameter logic [AW-1:0] BASE = 8'hF0
) (
    input logic          clk,
    input logic          rst_n,
    input logic          run_i,
    input logic          wide_i,
    input logic          tick_i,
    input logic          req_valid_i,
    input logic          req_write_i,
    input logic          req_size64_i,
    input logic [AW-1:0] req_addr_i,
    input logic          rsp_valid_o,
    input logic [CW-1:0] rsp_rdata_o,
    input logic          rsp_err_o,
    input logic          rsp_drop_o,
    input logic [CW-1:0] cnt_q
);
    localparam int unsigned HW = CW / 2;
    logic legal;
    assign legal = req_size64_i ? (req_addr_i == BASE)
                                : (req_addr_i == BASE || req_addr_i == BASE + AW'(4));

    a_r10_rsp_follows: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid_i |=> rsp_valid_o);
    a_r10_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid_i |=> !rsp_valid_o);
    a_r4_illegal_err: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && !legal) |=> (rsp_err_o && rsp_rdata_o == '0));
    a_r4_illegal_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && !legal && !run_i) |=> $stable(cnt_q));
    a_r5_drop_running: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && legal && req_write_i && run_i) |=> rsp_drop_o);
    a_r2_hold_halted: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_i && !(req_valid_i && req_write_i)) |=> $stable(cnt_q));
    a_r7_narrow_upper: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && !req_write_i && !wide_i) |=> (rsp_rdata_o[CW-1:HW] == '0));
    a_r9_read_bumps: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && req_valid_i && legal && !req_write_i) |=> (cnt_q != $past(cnt_q)));
    a_r2_tick_moves: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && tick_i) |=> (cnt_q != $past(cnt_q)));
endmodule

bind evt_main_counter evt_main_counter_chk #(.CW(CW), .AW(AW), .BASE(BASE)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .run_i        (run_i),
    .wide_i       (wide_i),
    .tick_i       (tick_i),
    .req_valid_i  (req_valid_i),
    .req_write_i  (req_write_i),
    .req_size64_i (req_size64_i),
    .req_addr_i   (req_addr_i),
    .rsp_valid_o  (rsp_valid_o),
    .rsp_rdata_o  (rsp_rdata_o),
    .rsp_err_o    (rsp_err_o),
    .rsp_drop_o   (rsp_drop_o),
    .cnt_q        (cnt_q)
);

// File: tb/tb_evt_main_counter.sv
module tb_evt_main_counter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run_i = 1'b0, wide_i = 1'b1, tick_i = 1'b0;
    logic        req_valid_i = 1'b0, req_write_i = 1'b0, req_size64_i = 1'b0;
    logic [7:0]  req_addr_i = '0;
    logic [63:0] req_wdata_i = '0;
    logic        rsp_valid_o, rsp_err_o, rsp_drop_o;
    logic [63:0] rsp_rdata_o;

    int unsigned errors = 0, checks = 0, cycles = 0;
    logic [63:0] mcnt = '0;   // bench model of the count
    logic [63:0] last_rd;

    always #4 clk = ~clk;   // 125 MHz

    evt_main_counter dut (.*);

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                errors++;
                checks++;
                $display("FAIL watchdog: actual=%0d expected<150000 cycles", cycles);
                finish_run();
            end
        end
    end

    function automatic logic legal_f(input logic s64, input logic [7:0] a);
        return s64 ? (a == 8'hF0) : (a == 8'hF0 || a == 8'hF4);
    endfunction

    function automatic logic [63:0] rd_f(input logic [63:0] c, input logic s64,
                                         input logic [7:0] a, input logic wide);
        if (s64)         return wide ? c : {32'h0, c[31:0]};
        if (a == 8'hF0)  return {32'h0, c[31:0]};
        return wide ? {32'h0, c[63:32]} : 64'h0;
    endfunction

    // Drive one cycle at posedge+2; sample the response at the next posedge+2.
    task automatic op(input logic v, input logic w, input logic s64, input logic [7:0] a,
                      input logic [63:0] wd, input logic tk, input logic rn, input logic wd_mode,
                      input string tag);
        logic        lg, exp_err, exp_drop;
        logic [63:0] exp_rd;
        req_valid_i = v; req_write_i = w; req_size64_i = s64; req_addr_i = a;
        req_wdata_i = wd; tick_i = tk; run_i = rn; wide_i = wd_mode;
        lg       = legal_f(s64, a);
        exp_err  = v && !lg;
        exp_drop = v && lg && w && rn;
        exp_rd   = (v && lg && !w) ? rd_f(mcnt, s64, a, wd_mode) : 64'h0;
        if (!rn) begin
            if (v && lg && w) begin
                if (s64)              mcnt = wd;
                else if (a == 8'hF0)  mcnt[31:0] = wd[31:0];
                else                  mcnt[63:32] = wd[31:0];
            end
        end else if (tk || (v && lg && !w)) begin
            if (wd_mode) mcnt = mcnt + 64'd1;
            else         mcnt[31:0] = mcnt[31:0] + 32'd1;
        end
        @(posedge clk);
        #2;
        chk("R10 rsp_valid", {63'h0, rsp_valid_o}, {63'h0, v});
        if (v) begin
            chk("R4 rsp_err", {63'h0, rsp_err_o}, {63'h0, exp_err});
            chk("R5 rsp_drop", {63'h0, rsp_drop_o}, {63'h0, exp_drop});
            chk(tag, rsp_rdata_o, exp_rd);
            if (!w) last_rd = rsp_rdata_o;
        end
        req_valid_i = 1'b0; tick_i = 1'b0;
    endtask

    task automatic rd64(input logic rn, input logic wm, input string tag);
        op(1'b1, 1'b0, 1'b1, 8'hF0, 64'h0, 1'b0, rn, wm, tag);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        #2;
        chk("R1 no response in reset", {63'h0, rsp_valid_o}, 64'h0);
        rst_n = 1'b1;
        @(posedge clk); #2;
        chk("R1 no response after reset", {63'h0, rsp_valid_o}, 64'h0);
        rd64(1'b0, 1'b1, "R1 reset count");
        chk("R1 count zero", last_rd, 64'h0);

        // Halted wide write, then hold while ticking halted
        op(1'b1, 1'b1, 1'b1, 8'hF0, 64'h1234_5678_9ABC_DEF0, 1'b0, 1'b0, 1'b1, "R5 write data");
        op(1'b0, 1'b0, 1'b0, 8'h00, 64'h0, 1'b1, 1'b0, 1'b1, "R2 idle");
        rd64(1'b0, 1'b1, "R2 hold halted");
        chk("R5 halted write loaded", last_rd, 64'h1234_5678_9ABC_DEF0);

        // Narrow half writes
        op(1'b1, 1'b1, 1'b0, 8'hF4, 64'hFFFF_0000_AAAA_BBBB, 1'b0, 1'b0, 1'b1, "R6 wr hi");
        rd64(1'b0, 1'b1, "R6 read");
        chk("R6 hi half only", last_rd, 64'hAAAA_BBBB_9ABC_DEF0);
        op(1'b1, 1'b1, 1'b0, 8'hF0, 64'h0000_0000_1111_2222, 1'b0, 1'b0, 1'b1, "R6 wr lo");
        rd64(1'b0, 1'b1, "R6 read");
        chk("R6 lo half only", last_rd, 64'hAAAA_BBBB_1111_2222);
        op(1'b1, 1'b0, 1'b0, 8'hF4, 64'h0, 1'b0, 1'b0, 1'b1, "R3 narrow hi read");
        chk("R3 narrow hi", last_rd, 64'h0000_0000_AAAA_BBBB);
        op(1'b1, 1'b0, 1'b0, 8'hF0, 64'h0, 1'b0, 1'b0, 1'b1, "R3 narrow lo read");

        // Illegal offsets
        op(1'b1, 1'b0, 1'b0, 8'hF1, 64'h0, 1'b0, 1'b0, 1'b1, "R4 illegal read data");
        op(1'b1, 1'b1, 1'b0, 8'hF5, 64'h5555_5555_5555_5555, 1'b0, 1'b0, 1'b1, "R4 illegal write");
        op(1'b1, 1'b0, 1'b1, 8'hF4, 64'h0, 1'b0, 1'b0, 1'b1, "R4 wide at F4");
        rd64(1'b0, 1'b1, "R4 read");
        chk("R4 count unchanged", last_rd, 64'hAAAA_BBBB_1111_2222);

        // Write while running is dropped
        op(1'b1, 1'b1, 1'b1, 8'hF0, 64'h0, 1'b0, 1'b1, 1'b1, "R5 dropped write");
        rd64(1'b0, 1'b1, "R5 read");
        chk("R5 count kept", last_rd, 64'hAAAA_BBBB_1111_2222);

        // Ticks while running
        for (int i = 0; i < 5; i++) op(1'b0, 1'b0, 1'b0, 8'h0, 64'h0, 1'b1, 1'b1, 1'b1, "R2 tick");
        rd64(1'b0, 1'b1, "R2 read");
        chk("R2 five ticks", last_rd, 64'hAAAA_BBBB_1111_2227);

        // Back-to-back reads while running, no ticks
        rd64(1'b1, 1'b1, "R9 read");
        for (int i = 0; i < 4; i++) begin
            logic [63:0] prev = last_rd;
            rd64(1'b1, 1'b1, "R9 read");
            chk("R9 strictly increasing", {63'h0, last_rd > prev}, 64'h1);
        end

        // Narrow-mode wrap and upper zero
        op(1'b1, 1'b1, 1'b0, 8'hF0, 64'hFFFF_FFFF, 1'b0, 1'b0, 1'b0, "R7 wr");
        op(1'b0, 1'b0, 1'b0, 8'h0, 64'h0, 1'b1, 1'b1, 1'b0, "R7 tick");
        op(1'b1, 1'b0, 1'b0, 8'hF0, 64'h0, 1'b0, 1'b0, 1'b0, "R7 narrow wrap");
        chk("R7 wrapped to zero", last_rd, 64'h0);
        rd64(1'b0, 1'b0, "R7 wide read narrow mode");
        chk("R7 upper zero", last_rd, 64'h0);
        op(1'b1, 1'b0, 1'b0, 8'hF4, 64'h0, 1'b0, 1'b0, 1'b0, "R7 hi read zero");

        // Wide-mode wrap
        op(1'b1, 1'b1, 1'b1, 8'hF0, '1, 1'b0, 1'b0, 1'b1, "R8 wr");
        op(1'b0, 1'b0, 1'b0, 8'h0, 64'h0, 1'b1, 1'b1, 1'b1, "R8 tick");
        rd64(1'b1, 1'b1, "R8 wide wrap");
        chk("R8 wrapped to zero", last_rd, 64'h0);

        // Random mix
        for (int i = 0; i < 3000; i++) begin
            logic [7:0] a;
            logic [63:0] wd;
            int unsigned k = $urandom_range(0, 9);
            a  = (k < 4) ? 8'hF0 : (k < 7) ? 8'hF4 : (k < 9) ? (8'hF0 | 8'($urandom_range(1, 7))) : 8'($urandom);
            wd = {$urandom, $urandom};
            if ($urandom_range(0, 7) == 0) wd[31:0] = 32'hFFFF_FFF0 | 32'($urandom_range(0, 15));
            op($urandom_range(0, 2) != 0, $urandom_range(0, 2) == 0, 1'($urandom), a, wd,
               1'($urandom), $urandom_range(0, 3) != 0, $urandom_range(0, 4) != 0, "R3 random read data");
        end
        finish_run();
    end
endmodule